// File: doc/BRIEF.md
# Next Program Counter Unit

This block owns the program counter of a 32-bit processor whose instructions are each four bytes wide and word-aligned. Every clock cycle it looks at the instruction currently held for the PC, decodes the control-flow kind from the major opcode field (and, for register-format words, the function field), and loads the PC with one of four candidates: the sequential address, a PC-relative conditional branch target, a region-absolute jump target, or a value read from a register.

For the two linking jumps it also drives a register-file write request: an enable, the destination register number and the return address. The return address skips one instruction beyond the jump so that the single delay-slot instruction is not executed twice. The branch condition comes from a dedicated equality flag produced by a comparator next to the register file, so an arithmetic result computed elsewhere can never steer fetch.

The reset input is asserted asynchronously and released through an internal synchronizer, so the PC stays at its reset value for a fixed number of rising edges after the reset input rises.

Top module: `npc_unit`

## Requirements
- R1: While `rst_n` is low, `pc` reads 0x00000000 and `link_we` is 0. After `rst_n` rises, `pc` stays 0x00000000 across the next two rising clock edges and first moves on the third.
- R2: Any instruction that is not one of the six control-flow encodings below (including an unknown major opcode and a register-format word with another function code) loads `pc + 4` and drives `link_we` low and `link_reg` to 0.
- R3: A word with opcode field `instr[31:26]` = 0x04 (branch-if-equal) loads `pc + 4 + (sign-extended instr[15:0] << 2)` when `rs_eq` is 1 and `pc + 4` when `rs_eq` is 0.
- R4: A word with opcode 0x05 (branch-if-not-equal) loads the same branch target when `rs_eq` is 0 and `pc + 4` when `rs_eq` is 1.
- R5: A word with opcode 0x02 (jump) loads `{pc[31:28], instr[25:0], 2'b00}`.
- R6: A word with opcode 0x00 and function field `instr[5:0]` = 0x08 (jump-register) loads `rs_val` and requests no link write.
- R7: A word with opcode 0x03 (jump-and-link) loads the same target as R5 and drives `link_we` = 1, `link_reg` = 31 and `link_data` = `pc + 8`.
- R8: A word with opcode 0x00 and function 0x09 (jump-and-link-register) loads `rs_val` and drives `link_we` = 1, `link_reg` = `instr[15:11]` and `link_data` = `pc + 8`.
- R9: `rs_eq` has no effect on `pc` or the link outputs for any word other than opcodes 0x04 and 0x05.
- R10: `rs_val` has no effect on `pc` or the link outputs for any word other than the two register-indirect jumps.
- R11: All address arithmetic wraps modulo 2^32, and a negative branch offset moves the PC backwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released synchronously inside |
| instr | input | 32 | Instruction word fetched from the current `pc` |
| rs_eq | input | 1 | 1 when the two source registers of the instruction compare equal |
| rs_val | input | 32 | Value of the first source register |
| pc | output | 32 | Registered program counter |
| link_we | output | 1 | Register-file write request for a linking jump |
| link_reg | output | 5 | Destination register of the link write, 0 when none |
| link_data | output | 32 | Return address, `pc + 8` |

## Verification
A wrong decode or a wrong candidate choice inside this block shows up at `pc` on the very next rising edge, because the PC register is the only state and every candidate is formed combinationally from the present `pc` and `instr`. A wrong link decision shows in the same cycle on `link_we`, `link_reg` and `link_data`, before any edge. An error in the reset synchronizer shows as the PC moving one edge too early or too late after `rst_n` rises, and once the PC is wrong every later address is offset, so the scoreboard catches it within a cycle and keeps flagging it.

// File: rtl/npc_pkg.sv
package npc_pkg;

  localparam int unsigned XLEN       = 32;
  localparam int unsigned REG_IDX_W  = 5;
  localparam int unsigned OPC_W      = 6;
  localparam int unsigned FUNCT_W    = 6;
  localparam int unsigned IMM_W      = 16;
  localparam int unsigned JIDX_W     = 26;
  localparam int unsigned INSN_BYTES = 4;
  localparam int unsigned WORD_SHIFT = 2;
  localparam int unsigned REGION_W   = XLEN - JIDX_W - WORD_SHIFT;

  // Major opcode and function codes that alter the flow of control.
  localparam logic [OPC_W-1:0]   OPC_RFMT = 6'h00;
  localparam logic [OPC_W-1:0]   OPC_JMP  = 6'h02;
  localparam logic [OPC_W-1:0]   OPC_JAL  = 6'h03;
  localparam logic [OPC_W-1:0]   OPC_BEQ  = 6'h04;
  localparam logic [OPC_W-1:0]   OPC_BNE  = 6'h05;
  localparam logic [FUNCT_W-1:0] FN_JR    = 6'h08;
  localparam logic [FUNCT_W-1:0] FN_JALR  = 6'h09;

  typedef enum logic [2:0] {
    CF_SEQ  = 3'd0,
    CF_BEQ  = 3'd1,
    CF_BNE  = 3'd2,
    CF_JMP  = 3'd3,
    CF_JAL  = 3'd4,
    CF_JR   = 3'd5,
    CF_JALR = 3'd6
  } cf_kind_e;

  typedef enum logic [1:0] {
    SRC_SEQ = 2'd0,
    SRC_BR  = 2'd1,
    SRC_ABS = 2'd2,
    SRC_REG = 2'd3
  } pc_src_e;

  typedef enum logic [1:0] {
    LDST_NONE = 2'd0,
    LDST_FIX  = 2'd1,
    LDST_RD   = 2'd2
  } link_dst_e;

  typedef struct packed {
    cf_kind_e  kind;
    logic      is_branch;
    pc_src_e   fixed_src;
    link_dst_e link_dst;
  } cf_ctrl_t;

endpackage

// File: rtl/npc_rst_sync.sv
module npc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic run
);

  localparam int unsigned LAST = STAGES - 1;

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  generate
    if (STAGES == 1) begin : g_single
      always_comb begin
        sync_d = 1'b1;
      end
    end else begin : g_chain
      always_comb begin
        sync_d = {sync_q[STAGES-2:0], 1'b1};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign run = sync_q[LAST];

endmodule

// File: rtl/npc_decode.sv
module npc_decode
  import npc_pkg::*;
(
  input  logic [OPC_W-1:0]   opcode,
  input  logic [FUNCT_W-1:0] funct,
  output cf_ctrl_t           ctrl
);

  always_comb begin
    ctrl.kind      = CF_SEQ;
    ctrl.is_branch = 1'b0;
    ctrl.fixed_src = SRC_SEQ;
    ctrl.link_dst  = LDST_NONE;
    case (opcode)
      OPC_BEQ: begin
        ctrl.kind      = CF_BEQ;
        ctrl.is_branch = 1'b1;
      end
      OPC_BNE: begin
        ctrl.kind      = CF_BNE;
        ctrl.is_branch = 1'b1;
      end
      OPC_JMP: begin
        ctrl.kind      = CF_JMP;
        ctrl.fixed_src = SRC_ABS;
      end
      OPC_JAL: begin
        ctrl.kind      = CF_JAL;
        ctrl.fixed_src = SRC_ABS;
        ctrl.link_dst  = LDST_FIX;
      end
      OPC_RFMT: begin
        case (funct)
          FN_JR: begin
            ctrl.kind      = CF_JR;
            ctrl.fixed_src = SRC_REG;
          end
          FN_JALR: begin
            ctrl.kind      = CF_JALR;
            ctrl.fixed_src = SRC_REG;
            ctrl.link_dst  = LDST_RD;
          end
          default: begin
            ctrl.kind = CF_SEQ;
          end
        endcase
      end
      default: begin
        ctrl.kind = CF_SEQ;
      end
    endcase
  end

endmodule

// File: rtl/npc_target.sv
module npc_target
  import npc_pkg::*;
(
  input  logic [XLEN-1:0]   pc_cur,
  input  logic [JIDX_W-1:0] low_field,
  input  logic [XLEN-1:0]   reg_tgt,
  input  logic              eq_flag,
  input  cf_ctrl_t          ctrl,
  output logic [XLEN-1:0]   pc_nxt,
  output logic [XLEN-1:0]   ret_addr
);

  localparam int unsigned SEXT_W = XLEN - IMM_W - WORD_SHIFT;
  localparam logic [XLEN-1:0] STEP     = XLEN'(INSN_BYTES);
  localparam logic [XLEN-1:0] RET_STEP = XLEN'(2 * INSN_BYTES);

  logic [XLEN-1:0] seq_addr;
  logic [XLEN-1:0] br_disp;
  logic [XLEN-1:0] br_addr;
  logic [XLEN-1:0] abs_addr;
  logic [IMM_W-1:0] imm;
  logic            take_br;
  pc_src_e         src;

  assign imm = low_field[IMM_W-1:0];

  always_comb begin
    seq_addr = pc_cur + STEP;
    br_disp  = {{SEXT_W{imm[IMM_W-1]}}, imm, {WORD_SHIFT{1'b0}}};
    br_addr  = seq_addr + br_disp;
    abs_addr = {pc_cur[XLEN-1 -: REGION_W], low_field, {WORD_SHIFT{1'b0}}};
    ret_addr = pc_cur + RET_STEP;
  end

  always_comb begin
    take_br = 1'b0;
    if (ctrl.is_branch) begin
      take_br = (ctrl.kind == CF_BEQ) ? eq_flag : !eq_flag;
    end
  end

  always_comb begin
    src = ctrl.fixed_src;
    if (take_br) begin
      src = SRC_BR;
    end
  end

  always_comb begin
    case (src)
      SRC_BR:  pc_nxt = br_addr;
      SRC_ABS: pc_nxt = abs_addr;
      SRC_REG: pc_nxt = reg_tgt;
      default: pc_nxt = seq_addr;
    endcase
  end

endmodule

// File: rtl/npc_unit.sv
module npc_unit
  import npc_pkg::*;
#(
  parameter logic [XLEN-1:0]      RESET_PC     = '0,
  parameter int unsigned          SYNC_STAGES  = 2,
  parameter logic [REG_IDX_W-1:0] LINK_REG_FIX = 5'd31
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [XLEN-1:0]      instr,
  input  logic                 rs_eq,
  input  logic [XLEN-1:0]      rs_val,
  output logic [XLEN-1:0]      pc,
  output logic                 link_we,
  output logic [REG_IDX_W-1:0] link_reg,
  output logic [XLEN-1:0]      link_data
);

  localparam int unsigned OPC_LSB = XLEN - OPC_W;
  localparam int unsigned RD_LSB  = 11;

  logic            run;
  logic            pc_en;
  cf_ctrl_t        ctrl;
  logic [XLEN-1:0] pc_q;
  logic [XLEN-1:0] pc_d;
  logic [XLEN-1:0] ret_addr;

  npc_rst_sync #(
    .STAGES (SYNC_STAGES)
  ) u_rst_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run)
  );

  npc_decode u_decode (
    .opcode (instr[OPC_LSB +: OPC_W]),
    .funct  (instr[FUNCT_W-1:0]),
    .ctrl   (ctrl)
  );

  npc_target u_target (
    .pc_cur    (pc_q),
    .low_field (instr[JIDX_W-1:0]),
    .reg_tgt   (rs_val),
    .eq_flag   (rs_eq),
    .ctrl      (ctrl),
    .pc_nxt    (pc_d),
    .ret_addr  (ret_addr)
  );

  assign pc_en = run;

  always_ff @(posedge clk or negedge run) begin
    if (!run) begin
      pc_q <= RESET_PC;
    end else if (pc_en) begin
      pc_q <= pc_d;
    end
  end

  always_comb begin
    link_we  = 1'b0;
    link_reg = '0;
    if (run) begin
      case (ctrl.link_dst)
        LDST_FIX: begin
          link_we  = 1'b1;
          link_reg = LINK_REG_FIX;
        end
        LDST_RD: begin
          link_we  = 1'b1;
          link_reg = instr[RD_LSB +: REG_IDX_W];
        end
        default: begin
          link_we  = 1'b0;
          link_reg = '0;
        end
      endcase
    end
  end

  assign pc        = pc_q;
  assign link_data = ret_addr;

endmodule

// File: rtl/npc_unit_chk.sv
module npc_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        run,
  input logic [31:0] instr,
  input logic        rs_eq,
  input logic [31:0] rs_val,
  input logic [31:0] pc,
  input logic        link_we,
  input logic [4:0]  link_reg,
  input logic [31:0] link_data
);

  logic [5:0]  op;
  logic [5:0]  fn;
  logic [31:0] br_tgt;
  logic        flow;

  assign op     = instr[31:26];
  assign fn     = instr[5:0];
  assign br_tgt = pc + 32'd4 + {{14{instr[15]}}, instr[15:0], 2'b00};
  assign flow   = (op == 6'h02) || (op == 6'h03) || (op == 6'h04) || (op == 6'h05) ||
                  ((op == 6'h00) && ((fn == 6'h08) || (fn == 6'h09)));

  // R1: reset holds the PC and silences the link port
  a_r1_reset_idle: assert property (@(posedge clk)
    !rst_n |-> (pc == 32'h0 && !link_we));

  // R1: the first edge after release does not move the PC
  a_r1_release_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |=> (pc == 32'h0));

  // R2: plain words step by one instruction
  a_r2_seq_step: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !flow) |=> (pc == $past(pc) + 32'd4));

  // R2: plain words request no link
  a_r2_no_link: assert property (@(posedge clk) disable iff (!rst_n)
    !flow |-> !link_we);

  // R3: equal branch taken
  a_r3_beq_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (run && op == 6'h04 && rs_eq) |=> (pc == $past(br_tgt)));

  // R4: not-equal branch taken
  a_r4_bne_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (run && op == 6'h05 && !rs_eq) |=> (pc == $past(br_tgt)));

  // R5: absolute jumps keep the upper region bits
  a_r5_abs_jump: assert property (@(posedge clk) disable iff (!rst_n)
    (run && (op == 6'h02 || op == 6'h03)) |=>
      (pc == {$past(pc[31:28]), $past(instr[25:0]), 2'b00}));

  // R6: register-indirect jumps follow rs_val
  a_r6_reg_jump: assert property (@(posedge clk) disable iff (!rst_n)
    (run && op == 6'h00 && (fn == 6'h08 || fn == 6'h09)) |=> (pc == $past(rs_val)));

  // R7: jump-and-link writes the fixed link register
  a_r7_jal_link: assert property (@(posedge clk) disable iff (!rst_n)
    (run && op == 6'h03) |-> (link_we && link_reg == 5'd31 && link_data == pc + 32'd8));

  // R8: jump-and-link-register writes rd
  a_r8_jalr_link: assert property (@(posedge clk) disable iff (!rst_n)
    (run && op == 6'h00 && fn == 6'h09) |->
      (link_we && link_reg == instr[15:11] && link_data == pc + 32'd8));

endmodule

bind npc_unit npc_unit_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .run       (run),
  .instr     (instr),
  .rs_eq     (rs_eq),
  .rs_val    (rs_val),
  .pc        (pc),
  .link_we   (link_we),
  .link_reg  (link_reg),
  .link_data (link_data)
);

// File: tb/npc_unit_tb.sv
module npc_unit_tb;

  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG_CYCLES = 200000;

  logic        clk;
  logic        rst_n;
  logic [31:0] instr;
  logic        rs_eq;
  logic [31:0] rs_val;
  logic [31:0] pc;
  logic        link_we;
  logic [4:0]  link_reg;
  logic [31:0] link_data;

  int n_checks;
  int n_fails;
  bit done;

  typedef struct {
    logic [31:0] pc;
    string       req;
  } exp_t;

  exp_t        sb_q[$];
  logic [31:0] model_pc;

  npc_unit u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .instr     (instr),
    .rs_eq     (rs_eq),
    .rs_val    (rs_val),
    .pc        (pc),
    .link_we   (link_we),
    .link_reg  (link_reg),
    .link_data (link_data)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  // Expected next PC, written from the requirements.
  function automatic logic [31:0] ref_next(input logic [31:0] p, input logic [31:0] w,
                                           input logic e, input logic [31:0] r);
    logic [31:0] seq;
    logic [31:0] brt;
    seq = p + 32'd4;
    brt = seq + {{14{w[15]}}, w[15:0], 2'b00};
    case (w[31:26])
      6'h04: return e ? brt : seq;
      6'h05: return e ? seq : brt;
      6'h02, 6'h03: return {p[31:28], w[25:0], 2'b00};
      6'h00: begin
        if (w[5:0] == 6'h08 || w[5:0] == 6'h09) return r;
        return seq;
      end
      default: return seq;
    endcase
  endfunction

  // Monitor: pops one expectation per cycle, a cycle after it was pushed.
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      check(pc === e.pc, e.req, pc, e.pc);
    end
  end

  // Driver: call just after a falling edge.
  task automatic drive(input logic [31:0] w, input logic e, input logic [31:0] r,
                       input string req);
    exp_t        item;
    logic        exp_we;
    logic [4:0]  exp_reg;
    exp_we  = 1'b0;
    exp_reg = 5'd0;
    if (w[31:26] == 6'h03) begin
      exp_we  = 1'b1;
      exp_reg = 5'd31;
    end else if (w[31:26] == 6'h00 && w[5:0] == 6'h09) begin
      exp_we  = 1'b1;
      exp_reg = w[15:11];
    end
    instr  = w;
    rs_eq  = e;
    rs_val = r;
    #1;
    check(pc === model_pc, {req, " pc before edge"}, pc, model_pc);
    check(link_we === exp_we, {req, " link_we"}, 32'(link_we), 32'(exp_we));
    check(link_reg === exp_reg, {req, " link_reg"}, 32'(link_reg), 32'(exp_reg));
    if (exp_we) begin
      check(link_data === model_pc + 32'd8, {req, " link_data"}, link_data,
            model_pc + 32'd8);
    end
    model_pc  = ref_next(model_pc, w, e, r);
    item.pc   = model_pc;
    item.req  = req;
    sb_q.push_back(item);
  endtask

  task automatic step(input logic [31:0] w, input logic e, input logic [31:0] r,
                      input string req);
    @(negedge clk);
    #1;
    drive(w, e, r, req);
  endtask

  task automatic release_and_check();
    rst_n = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    #1;
    check(pc === 32'h0, "R1 pc held for two edges after release", pc, 32'h0);
    model_pc = 32'h0;
  endtask

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog expired actual=0x%08h expected=0x%08h", pc, 32'h0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    n_checks = 0;
    n_fails  = 0;
    done     = 1'b0;
    model_pc = 32'h0;
    rst_n    = 1'b0;
    instr    = 32'h0;
    rs_eq    = 1'b0;
    rs_val   = 32'h0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1;
    check(pc === 32'h0, "R1 pc in reset", pc, 32'h0);
    check(link_we === 1'b0, "R1 link_we in reset", 32'(link_we), 32'h0);
    instr = 32'h0;

    release_and_check();
    drive(32'h0000_0000, 1'b1, 32'hDEAD_BEEF, "R2 R9 R10 nop");
    step(32'hFC00_1234, 1'b1, 32'h1111_1111, "R2 unknown opcode");
    step(32'h0123_4020, 1'b0, 32'h2222_2222, "R2 other funct");
    step(32'h0140_0008, 1'b1, 32'h0000_1000, "R6 jump-register");
    step(32'h114B_000C, 1'b1, 32'h5555_5555, "R3 equal taken");
    step(32'h114B_000C, 1'b0, 32'h0, "R3 equal not taken");
    step(32'h154B_000C, 1'b0, 32'h0, "R4 not-equal taken");
    step(32'h154B_000C, 1'b1, 32'h0, "R4 not-equal not taken");
    step(32'h1000_FFFF, 1'b1, 32'h0, "R11 negative offset");
    step(32'h0140_0008, 1'b0, 32'h1000_0000, "R6 jump-register high");
    step(32'h0800_2000, 1'b1, 32'h0000_0055, "R5 R9 R10 jump");
    step(32'h0C00_0100, 1'b1, 32'hAAAA_AAAA, "R7 jump-and-link");
    step(32'h0140_2809, 1'b1, 32'hFFFF_FFFC, "R8 jump-and-link-register");
    step(32'h0000_0000, 1'b0, 32'h0, "R11 wrap to zero");
    step(32'h0BFF_FFFF, 1'b0, 32'h0, "R5 full target field");
    step(32'h1400_8000, 1'b0, 32'h0, "R11 most negative offset");
    step(32'h0000_F809, 1'b0, 32'h0000_0040, "R8 rd field 31");
    step(32'h1000_0004, 1'b0, 32'h7777_7777, "R9 R10 branch ignores rs_val");

    @(negedge clk);
    #1;
    instr = 32'h0C00_0100;
    rst_n = 1'b0;
    #1;
    check(pc === 32'h0, "R1 pc on async reset", pc, 32'h0);
    check(link_we === 1'b0, "R1 link_we quiet in reset", 32'(link_we), 32'h0);
    repeat (2) @(posedge clk);
    @(negedge clk);
    #1;
    instr = 32'h0;
    release_and_check();
    drive(32'h0000_0000, 1'b0, 32'h0, "R1 R2 first step after release");
    step(32'h0000_0000, 1'b0, 32'h0, "R2 second step");
    @(negedge clk);
    #1;

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule